// File: doc/BRIEF.md
# Word Serializer with Internal Wrap

The block turns a stream of 20-bit parallel words into a serial bit stream that carries twenty bits per word period. One fast bit clock drives all of its logic, and a 0..19 bit counter inside it stands in for the word clock. The counter raises `word_tick_o` for the last bit slot of each word period. On the clock edge that closes that slot, the block captures the word on `word_i` and the wrap control on `wrap_i`. The word that was captured one period earlier then moves into the shift register and is sent during the next twenty cycles, least significant bit first. The data is expected to arrive already line-coded. Bits 0..9 form the first 10-bit code character and bits 10..19 form the second.

The wrap control is captured together with its word and stays attached to that word. A word sent with wrap low drives the differential line outputs with its bits. A word sent with wrap high has its bits routed to an internal loopback output that feeds a receiver, and the line is held at a static high level for that word. After reset, the line idles low until the first captured word reaches the shift register.

Top module: `word_serializer`

## Requirements
- R1: The bit counter runs 0..19 and then repeats. `word_tick_o` is high exactly while the count is 19. After reset is released, the first tick appears on the 19th clock edge.
- R2: `word_i` and `wrap_i` are sampled only on the clock edge that ends a tick cycle. Changes to them at any other time have no effect on the serial output.
- R3: A word captured at a word edge is sent during the following word period, one bit per clock. Bit k appears while the count equals k, so bit 0 goes first and bit 19 goes last.
- R4: The first code character is sent before the second. Its bits a,b,c,d,e,i,f,g,h,j sit at bit positions 0..9, and the second character's bits sit at positions 10..19 in the same order.
- R5: While the word being sent was captured with wrap high, `line_p_o`=1 and `line_n_o`=0 for all twenty bit slots.
- R6: While the word being sent was captured with wrap high, `loop_o` carries the serial bit. Otherwise `loop_o` is 0.
- R7: While the word being sent was captured with wrap low, `line_p_o` equals the serial bit and `line_n_o` equals its complement.
- R8: Reset clears the counter and shift register. Until the first captured word reaches the shift register, which is the second word period after reset, the outputs idle with `line_p_o`=0, `line_n_o`=1 and `loop_o`=0.
- R9: The wrap setting only changes at word boundaries, so no word is ever split between the line and the loopback output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock, twenty cycles per word |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 20 | Pre-coded parallel word, sampled at the word edge |
| wrap_i | input | 1 | Internal loopback select, sampled with the word |
| word_tick_o | output | 1 | High in the last bit slot of each word period |
| line_p_o | output | 1 | Line output, true leg |
| line_n_o | output | 1 | Line output, complement leg |
| loop_o | output | 1 | Serial stream toward the receiver in wrap mode |

## Verification
The bench checks every bit slot of words that hold all zeros, all ones, alternating patterns and a comma-bearing character pair. A design that shifted the wrong way or was off by one slot would send bit 19 first or skew each bit by one clock. Some words toggle wrap on, then off, then on again, which exposes a design that samples wrap in the middle of a period: it would split a word between the line and the loopback. During each period the bench scrambles `word_i` and `wrap_i` and restores them before the tick, so a design that captures at any edge other than the word edge sends corrupted bits. A reset in the middle of a run confirms that the line idles low for two periods and that the first tick arrives on time; a design that skipped the input stage would show data one period early.

// File: rtl/wser_pkg.sv
package wser_pkg;
  localparam int unsigned WORD_W = 20;
  localparam int unsigned CHAR_W = 10;
endpackage

// File: rtl/wser_bit_ctr.sv
module wser_bit_ctr #(
  parameter int unsigned N = 20,
  localparam int unsigned CNT_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_W'(N-1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(N));

  // R1
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> cnt_q == '0);

  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/wser_shift.sv
module wser_shift #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         wrap_i,
  output logic         bit_o,
  output logic         wrap_o,
  output logic         vld_o
);
  logic [W-1:0] hold_q, sh_q;
  logic         hold_wrap_q, hold_vld_q, sh_wrap_q, sh_vld_q;

  // input stage: word and wrap travel together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_wrap_q <= 1'b0;
      hold_vld_q  <= 1'b0;
    end else if (load_i) begin
      hold_q      <= word_i;
      hold_wrap_q <= wrap_i;
      hold_vld_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      sh_wrap_q <= 1'b0;
      sh_vld_q  <= 1'b0;
    end else if (load_i) begin
      sh_q      <= hold_q;
      sh_wrap_q <= hold_wrap_q;
      sh_vld_q  <= hold_vld_q;
    end else begin
      sh_q      <= sh_q >> 1;
    end
  end

  assign bit_o  = sh_q[0];
  assign wrap_o = sh_wrap_q;
  assign vld_o  = sh_vld_q;

  // R3
  sh_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sh_q == $past(hold_q));

  // R3
  sh_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> sh_q == ($past(sh_q) >> 1));

  // R2
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(hold_q) && $stable(hold_wrap_q));

  // R9
  wrap_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(sh_wrap_q));
endmodule

// File: rtl/wser_line.sv
module wser_line (
  input  logic sbit_i,
  input  logic wrap_i,
  input  logic vld_i,
  output logic line_p_o,
  output logic line_n_o,
  output logic loop_o
);
  always_comb begin
    if (!vld_i) begin
      line_p_o = 1'b0;
      line_n_o = 1'b1;
      loop_o   = 1'b0;
    end else if (wrap_i) begin
      line_p_o = 1'b1;
      line_n_o = 1'b0;
      loop_o   = sbit_i;
    end else begin
      line_p_o = sbit_i;
      line_n_o = ~sbit_i;
      loop_o   = 1'b0;
    end
  end
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int unsigned WORD_W = wser_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              wrap_i,
  output logic              word_tick_o,
  output logic              line_p_o,
  output logic              line_n_o,
  output logic              loop_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0] cnt;
  logic             last, sbit, swrap, svld;

  wser_bit_ctr #(.N(WORD_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt),
    .last_o(last)
  );

  wser_shift #(.W(WORD_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(last),
    .word_i(word_i),
    .wrap_i(wrap_i),
    .bit_o (sbit),
    .wrap_o(swrap),
    .vld_o (svld)
  );

  wser_line u_line (
    .sbit_i  (sbit),
    .wrap_i  (swrap),
    .vld_i   (svld),
    .line_p_o(line_p_o),
    .line_n_o(line_n_o),
    .loop_o  (loop_o)
  );

  assign word_tick_o = last;

  // R5
  wrap_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svld && swrap) |-> (line_p_o && !line_n_o));

  // R8
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svld |-> (!line_p_o && line_n_o && !loop_o));

  // R1
  tick_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_tick_o |-> cnt == CNT_W'(WORD_W-1));
endmodule

// File: tb/word_serializer_bench.sv
module word_serializer_bench;
  localparam int W = 20;
  localparam int NV = 8;
  // {wrap, word}
  localparam logic [W:0] VEC [NV] = '{
    {1'b0, 20'h00000},
    {1'b0, 20'hFFFFF},
    {1'b1, 20'h5A5A5},
    {1'b0, 20'hAAAAA},
    {1'b1, 20'h55555},
    {1'b1, 20'h0F83E},
    {1'b0, 20'hC17C1},
    {1'b0, 20'h80001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] word = '0;
  logic wrap = 1'b0;
  logic tick, lp, ln, lb;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  word_serializer u_word_serializer (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .wrap_i(wrap),
    .word_tick_o(tick), .line_p_o(lp), .line_n_o(ln), .loop_o(lb)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, {lp, ln, lb}, 3'b010);
  endtask

  // expects a released reset at a negedge; checks first tick at 19 edges
  task automatic wait_first_tick();
    int n = 0;
    while (!tick && n < 40) begin
      @(negedge clk);
      n++;
      if (!tick) chk_idle("R8 idle before tick");
    end
    chk("R1 first tick delay", n, 19);
  endtask

  // check one word period against expected word/wrap (vld=0 => idle)
  task automatic check_window(input logic [W-1:0] w, input logic wr, input bit vld,
                              input logic [W-1:0] nxt_w, input logic nxt_wr);
    for (int b = 0; b < W; b++) begin
      @(negedge clk);
      if (!vld) chk_idle("R8 idle period");
      else if (wr) begin
        chk(b < 10 ? "R5 wrap line high char0" : "R5 wrap line high char1",
            {lp, ln}, 2'b10);
        chk("R6 loopback bit", lb, w[b]);
      end else begin
        chk(b < 10 ? "R3 R4 line bit char0" : "R3 R4 line bit char1", lp, w[b]);
        chk("R7 line complement", ln, !w[b]);
        chk("R6 loopback quiet", lb, 0);
      end
      chk("R1 tick position", tick, (b == W-1) ? 1 : 0);
      if (b == 5)  begin word = ~nxt_w; wrap = ~nxt_wr; end // R2 disturbance
      if (b == 12) begin word = 20'h3C3C3; wrap = 1'b1; end
      if (b == W-1) begin word = nxt_w; wrap = nxt_wr; end
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R8 in reset");
    chk("R1 no tick in reset", tick, 0);
    rst_n = 1'b1;
    wait_first_tick();
    // tick cycle: present vec[0]
    word = VEC[0][W-1:0]; wrap = VEC[0][W];
    for (int k = 0; k <= NV; k++) begin
      logic [W-1:0] nw;
      logic nwr;
      nw  = (k + 1 < NV) ? VEC[k+1][W-1:0] : 20'h12345;
      nwr = (k + 1 < NV) ? VEC[k+1][W] : 1'b0;
      if (k == 0) check_window('0, 1'b0, 1'b0, nw, nwr);
      else        check_window(VEC[k-1][W-1:0], VEC[k-1][W], 1'b1, nw, nwr);
    end
    // R9: wrap flipped within words already covered; reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R8 async reset");
    chk("R1 tick cleared", tick, 0);
    word = 20'hFEDCB; wrap = 1'b0;
    rst_n = 1'b1;
    wait_first_tick();
    word = 20'h0F0F1; wrap = 1'b0;
    check_window('0, 1'b0, 1'b0, 20'h0F0F1, 1'b0);
    check_window(20'h0F0F1, 1'b0, 1'b1, 20'h0, 1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule